// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block keeps the single atomic-access reservation of one processor core. The core issues plain loads, plain stores, load-with-reservation requests and store-conditional requests, each with a byte address. Two snoop ports observe writes made by other bus masters on two separate buses. The block holds one reserved word address and a valid flag, and it decides for each store-conditional whether the store may reach memory.

A lost reservation is never signalled on its own. The loss shows up only in the status of the next store-conditional. The write-enable gate is combinational in the cycle of the store-conditional request, so memory can use it directly. The pass/fail status follows one cycle later. Matching works on whole 32-bit words: the two low address bits are ignored. As a result, a byte or halfword write by another master anywhere in the reserved word cancels the reservation.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no reservation exists: a store-conditional issued before any load-with-reservation fails, and `sc_done`, `sc_pass` and `sc_wr_en` are low while reset is held.
- R2: A load-with-reservation (`cpu_op` = 2'b10) records the word address (address bits above bit 1) and sets the flag. A later store-conditional (`cpu_op` = 2'b11) to any byte of that word passes.
- R3: A new load-with-reservation replaces the earlier address. A store-conditional to the old word then fails.
- R4: Every store-conditional clears the flag, whether it passes or fails, so a second store-conditional without a fresh reservation fails.
- R5: A store-conditional to a word other than the reserved one fails and still clears the flag.
- R6: A plain store (`cpu_op` = 2'b01) by the core, even to the reserved word, and a plain load (`cpu_op` = 2'b00) leave the reservation unchanged.
- R7: A write seen on either snoop port whose address falls in the reserved word, at any byte offset, clears the flag.
- R8: A snooped write to a different word does not affect the reservation.
- R9: When a snoop hit and a store-conditional to the reserved word arrive in the same cycle, the snoop wins: the store-conditional fails and `sc_wr_en` stays low.
- R10: When a snoop hit and a load-with-reservation arrive in the same cycle, the new reservation is set.
- R11: `sc_done` is high for exactly the one cycle after each store-conditional request and at no other time. `sc_pass` is high only together with `sc_done`.
- R12: `sc_wr_en` is high only in the cycle of a store-conditional request that passes, and it agrees with the `sc_pass` reported in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core request valid |
| cpu_op | input | 2 | 00 load, 01 store, 10 load-with-reservation, 11 store-conditional |
| cpu_addr | input | ADDR_W | Core byte address |
| snp_a_wr | input | 1 | Foreign write seen on bus A |
| snp_a_addr | input | ADDR_W | Byte address of the bus A write |
| snp_b_wr | input | 1 | Foreign write seen on bus B |
| snp_b_addr | input | ADDR_W | Byte address of the bus B write |
| sc_wr_en | output | 1 | Store-conditional may write memory (same cycle) |
| sc_done | output | 1 | Status valid, one cycle after a store-conditional |
| sc_pass | output | 1 | Store-conditional succeeded |

## Verification
The bench targets the same-cycle collisions. A snoop hit arriving together with a store-conditional must make it fail; a design that updates the flag before it checks it would let a cancelled store reach memory. A snoop hit arriving together with a load-with-reservation must leave the new reservation set; a design that gives the snoop priority here would lose the new reservation. Foreign byte writes at every offset inside the reserved word and writes just outside it are driven on both buses, so an address compare that includes the low bits, or that covers only one bus, shows up as a wrong pass or fail. Plain core stores to the reserved word, mismatched store-conditionals and back-to-back store-conditionals catch designs that clear the flag too often or too rarely.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              snp_a_wr,
  input  logic [ADDR_W-1:0] snp_a_addr,
  input  logic              snp_b_wr,
  input  logic [ADDR_W-1:0] snp_b_addr,
  output logic              sc_wr_en,
  output logic              sc_done,
  output logic              sc_pass
);
  localparam int TAG_W = ADDR_W - WORD_LSB;
  localparam logic [1:0] OP_LR = 2'b10;
  localparam logic [1:0] OP_SC = 2'b11;

  logic             resv_valid;
  logic [TAG_W-1:0] resv_tag;

  wire [TAG_W-1:0] cpu_tag   = TAG_W'(cpu_addr >> WORD_LSB);
  wire [TAG_W-1:0] snp_a_tag = TAG_W'(snp_a_addr >> WORD_LSB);
  wire [TAG_W-1:0] snp_b_tag = TAG_W'(snp_b_addr >> WORD_LSB);

  wire is_lr     = cpu_req && (cpu_op == OP_LR);
  wire is_sc     = cpu_req && (cpu_op == OP_SC);
  wire snoop_hit = resv_valid &&
                   ((snp_a_wr && (snp_a_tag == resv_tag)) ||
                    (snp_b_wr && (snp_b_tag == resv_tag)));

  assign sc_wr_en = is_sc && resv_valid && (cpu_tag == resv_tag) && !snoop_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      sc_done    <= 1'b0;
      sc_pass    <= 1'b0;
    end else begin
      sc_done <= is_sc;
      sc_pass <= sc_wr_en;
      if (is_lr)
        resv_valid <= 1'b1;
      else if (is_sc || snoop_hit)
        resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (is_lr) resv_tag <= cpu_tag;
  end
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic [1:0] cpu_op,
  input logic       snp_a_wr,
  input logic       snp_b_wr,
  input logic       resv_valid,
  input logic       sc_wr_en,
  input logic       sc_done,
  input logic       sc_pass
);
  AST_SC_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_op == 2'b11) |=> !resv_valid); // R4
  AST_LR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_op == 2'b10) |=> resv_valid); // R10
  AST_STORE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_op == 2'b01 && resv_valid && !snp_a_wr && !snp_b_wr) |=> resv_valid); // R6
  AST_DONE_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_op == 2'b11) |=> sc_done); // R11
  AST_DONE_ONLY_AFTER_SC: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(cpu_req && cpu_op == 2'b11)); // R11
  AST_PASS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> sc_done); // R11
  AST_WE_THEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr_en |=> sc_pass); // R12
  AST_WE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    sc_wr_en |-> resv_valid); // R12
endmodule

bind lrsc_monitor lrsc_monitor_chk u_chk (.*);

// File: tb/lrsc_monitor_tb.sv
module lrsc_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0;
  logic [1:0]  cpu_op = 2'b00;
  logic [31:0] cpu_addr = '0;
  logic        snp_a_wr = 1'b0;
  logic [31:0] snp_a_addr = '0;
  logic        snp_b_wr = 1'b0;
  logic [31:0] snp_b_addr = '0;
  logic        sc_wr_en, sc_done, sc_pass;

  int n_cmp = 0;
  int n_bad = 0;
  bit m_valid = 0;
  logic [29:0] m_tag = '0;
  bit e_done = 0, e_pass = 0, e_we = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  lrsc_monitor u_dut (.*);

  task automatic check(string tag, string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit model_hit();
    return m_valid && ((snp_a_wr && snp_a_addr[31:2] == m_tag) ||
                       (snp_b_wr && snp_b_addr[31:2] == m_tag));
  endfunction

  always @(posedge clk) begin
    bit hit, sc, ok;
    hit = model_hit();
    sc  = cpu_req && cpu_op == 2'b11;
    ok  = sc && m_valid && cpu_addr[31:2] == m_tag && !hit;
    if (!rst_n) begin
      m_valid = 0; e_done = 0; e_pass = 0;
    end else begin
      e_done = sc;
      e_pass = ok;
      if (cpu_req && cpu_op == 2'b10) begin
        m_valid = 1; m_tag = cpu_addr[31:2];
      end else if (sc || hit) m_valid = 0;
    end
  end

  always @(negedge clk) begin
    check(cur_tag, "sc_done", sc_done, e_done);
    check(cur_tag, "sc_pass", sc_pass, e_pass);
  end

  task automatic step(string tag, bit req, logic [1:0] op, logic [31:0] a,
                      bit wa, logic [31:0] aa, bit wb, logic [31:0] ab);
    @(negedge clk);
    cur_tag = tag;
    cpu_req = req; cpu_op = op; cpu_addr = a;
    snp_a_wr = wa; snp_a_addr = aa; snp_b_wr = wb; snp_b_addr = ab;
    #1;
    e_we = rst_n && req && op == 2'b11 && m_valid && a[31:2] == m_tag && !model_hit();
    check(tag, "sc_wr_en", sc_wr_en, e_we);
  endtask

  task automatic cpu(string tag, logic [1:0] op, logic [31:0] a);
    step(tag, 1, op, a, 0, 0, 0, 0);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 2'b00, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: outputs low in reset, even with an SC presented
    cpu("R1", 2'b11, 32'h100);
    idle("R1");
    @(negedge clk); rst_n = 1'b1;
    cpu("R1", 2'b11, 32'h100);  idle("R1");
    // R2: reserve and pass at another byte of the same word
    cpu("R2", 2'b10, 32'h1000); cpu("R2", 2'b11, 32'h1003); idle("R2");
    // R4: second SC without reservation fails, back-to-back
    cpu("R4", 2'b10, 32'h2000); cpu("R4", 2'b11, 32'h2000); cpu("R4", 2'b11, 32'h2000); idle("R4");
    // R3: replacement
    cpu("R3", 2'b10, 32'h3000); cpu("R3", 2'b10, 32'h3100);
    cpu("R3", 2'b11, 32'h3000); idle("R3");
    cpu("R3", 2'b10, 32'h3000); cpu("R3", 2'b10, 32'h3100); cpu("R3", 2'b11, 32'h3102); idle("R3");
    // R5: mismatch fails and clears
    cpu("R5", 2'b10, 32'h4000); cpu("R5", 2'b11, 32'h4004); cpu("R5", 2'b11, 32'h4000); idle("R5");
    // R6: own store and load keep the reservation
    cpu("R6", 2'b10, 32'h5000); cpu("R6", 2'b01, 32'h5000); cpu("R6", 2'b01, 32'h5002);
    cpu("R6", 2'b00, 32'h5000); cpu("R6", 2'b00, 32'h6000); cpu("R6", 2'b11, 32'h5001); idle("R6");
    // R7: foreign byte writes at each offset, both buses
    for (int off = 0; off < 4; off++) begin
      cpu("R7", 2'b10, 32'h7000);
      step("R7", 0, 2'b00, 0, 1, 32'h7000 + off, 0, 0);
      cpu("R7", 2'b11, 32'h7000);
      cpu("R7", 2'b10, 32'h7000);
      step("R7", 0, 2'b00, 0, 0, 0, 1, 32'h7000 + off);
      cpu("R7", 2'b11, 32'h7000);
    end
    idle("R7");
    // R8: writes to neighbouring words on both buses keep it
    cpu("R8", 2'b10, 32'h8004);
    step("R8", 0, 2'b00, 0, 1, 32'h8003, 1, 32'h8008);
    step("R8", 0, 2'b00, 0, 1, 32'h8000, 0, 32'h8004);
    cpu("R8", 2'b11, 32'h8004); idle("R8");
    // R9: snoop and SC collide, on each bus
    cpu("R9", 2'b10, 32'h9000);
    step("R9", 1, 2'b11, 32'h9000, 1, 32'h9001, 0, 0); idle("R9");
    cpu("R9", 2'b10, 32'h9000);
    step("R9", 1, 2'b11, 32'h9000, 0, 0, 1, 32'h9002); idle("R9");
    // R10: snoop on old word and new LR collide; also snoop on the new word
    cpu("R10", 2'b10, 32'hA000);
    step("R10", 1, 2'b10, 32'hA100, 1, 32'hA000, 0, 0);
    cpu("R10", 2'b11, 32'hA100);
    cpu("R10", 2'b10, 32'hA000);
    step("R10", 1, 2'b10, 32'hA000, 0, 0, 1, 32'hA000);
    cpu("R10", 2'b11, 32'hA000); idle("R10");
    // R11 / R12: status only after SC; gate only on passing SC
    for (int i = 0; i < 3; i++) idle("R11");
    cpu("R12", 2'b10, 32'hB000); cpu("R12", 2'b01, 32'hB000);
    cpu("R12", 2'b11, 32'hB000); cpu("R12", 2'b00, 32'hB000); idle("R12");
    // R1: reset drops a live reservation
    cpu("R1", 2'b10, 32'hC000);
    @(negedge clk); rst_n = 1'b0; cpu_req = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cpu("R1", 2'b11, 32'hC000); idle("R1"); idle("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule